// File: doc/BRIEF.md
# Sensor Frame Assembler

This block turns one set of sensor readings into a fixed nine-byte frame and hands the bytes one at a time to a serial transmitter over a valid/ready byte interface. The readings are two 16-bit range values (left and right), an 8-bit acoustic sample, two presence-detector bits and six general-purpose status bits. A one-cycle send strobe starts a frame.

When the assembler accepts a strobe, it copies every input field into a holding register. The byte stream comes from that copy, so the sensor inputs may change freely while the frame drains. The frame has two start markers, the two range fields with the most significant byte first, the acoustic byte, a packed status byte and one end marker. It has no addressing and no checksum. A strobe that arrives while a frame is still being sent is dropped.

Top module: `sensor_frame_packer`

## Requirements
- R1: After reset `tx_valid_o` is low and stays low until a send strobe is accepted.
- R2: A frame is exactly nine bytes. `tx_valid_o` rises in the cycle after the clock edge that accepts `send_i`.
- R3: Byte 0 is 0x45, byte 1 is 0x47 and byte 8 is 0x59.
- R4: Bytes 2 to 5 are the left range value (bits 15:8, then bits 7:0), followed by the right range value (bits 15:8, then bits 7:0).
- R5: Byte 6 is the acoustic sample. Byte 7 is the status byte: bit 7 is the right presence bit, bit 6 is the left presence bit, and bits 5:0 are the general-purpose bits.
- R6: The frame carries the input values present at the edge that accepted the strobe. Input changes after that edge have no effect on the frame.
- R7: A byte is consumed only on a clock edge where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values.
- R8: `send_i` is ignored while a frame is in progress. After the ninth handshake, `tx_valid_o` is low in the next cycle and stays low until a new strobe arrives.
- R9: A strobe is accepted only while idle. A strobe present on the edge of the final handshake does not start a frame. A strobe held high through that edge starts the next frame one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Frame start strobe |
| range_left_i | input | 16 | Left range reading |
| range_right_i | input | 16 | Right range reading |
| audio_i | input | 8 | Acoustic sample |
| pres_right_i | input | 1 | Right presence detector |
| pres_left_i | input | 1 | Left presence detector |
| gp_i | input | 6 | General-purpose status bits |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_valid_o | output | 1 | A frame byte is presented |
| tx_data_o | output | 8 | Current frame byte |

## Verification
The hardest cases to reach are the ones where input activity overlaps the frame in flight. The first is a strobe that coincides with the final handshake; the second is inputs and strobes that change on every cycle while bytes are still draining under backpressure. The stimulus reaches the first case by holding `send_i` high for a whole frame, then checking the idle gap and the contents of the second frame. For the second case, the receive loop scrambles every input and toggles the strobe on each cycle while `tx_ready_i` follows a stall pattern.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned FRAME_LEN = 9;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned RANGE_W   = 16;
  localparam int unsigned AUDIO_W   = 8;
  localparam int unsigned GP_W      = 6;

  localparam logic [IDX_W-1:0] POS_SOF0  = IDX_W'(0);
  localparam logic [IDX_W-1:0] POS_SOF1  = IDX_W'(1);
  localparam logic [IDX_W-1:0] POS_LHI   = IDX_W'(2);
  localparam logic [IDX_W-1:0] POS_LLO   = IDX_W'(3);
  localparam logic [IDX_W-1:0] POS_RHI   = IDX_W'(4);
  localparam logic [IDX_W-1:0] POS_RLO   = IDX_W'(5);
  localparam logic [IDX_W-1:0] POS_AUDIO = IDX_W'(6);
  localparam logic [IDX_W-1:0] POS_STAT  = IDX_W'(7);
  localparam logic [IDX_W-1:0] POS_LAST  = IDX_W'(FRAME_LEN - 1);

  typedef struct packed {
    logic [RANGE_W-1:0] range_left;
    logic [RANGE_W-1:0] range_right;
    logic [AUDIO_W-1:0] audio;
    logic               pres_right;
    logic               pres_left;
    logic [GP_W-1:0]    gp;
  } sample_t;
endpackage

// File: rtl/sfp_snapshot.sv
module sfp_snapshot
  import sfp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  sample_t sample_i,
  output sample_t sample_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= '0;
    else if (load_i) sample_o <= sample_i;
  end
endmodule

// File: rtl/sfp_sequencer.sv
module sfp_sequencer
  import sfp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o
);
  logic xfer;

  assign load_o = send_i && !active_o;
  assign xfer   = active_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      idx_o    <= '0;
    end else if (load_o) begin
      active_o <= 1'b1;
      idx_o    <= '0;
    end else if (xfer) begin
      if (idx_o == POS_LAST) begin
        active_o <= 1'b0;
        idx_o    <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end

  assert_idx_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> idx_o <= POS_LAST);

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !ready_i |=> active_o && $stable(idx_o));

  assert_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && ready_i && idx_o == POS_LAST |=> !active_o);

  assert_ignore_send_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && send_i && !ready_i |=> active_o && $stable(idx_o));
endmodule

// File: rtl/sfp_byte_mux.sv
module sfp_byte_mux
  import sfp_pkg::*;
#(
  parameter logic [7:0] SOF0 = 8'h45,
  parameter logic [7:0] SOF1 = 8'h47,
  parameter logic [7:0] EOF  = 8'h59
) (
  input  logic [IDX_W-1:0] idx_i,
  input  sample_t          sample_i,
  output logic [7:0]       byte_o
);
  logic [7:0] status;

  assign status = {sample_i.pres_right, sample_i.pres_left, sample_i.gp};

  always_comb begin
    unique case (idx_i)
      POS_SOF0:  byte_o = SOF0;
      POS_SOF1:  byte_o = SOF1;
      POS_LHI:   byte_o = sample_i.range_left[15:8];
      POS_LLO:   byte_o = sample_i.range_left[7:0];
      POS_RHI:   byte_o = sample_i.range_right[15:8];
      POS_RLO:   byte_o = sample_i.range_right[7:0];
      POS_AUDIO: byte_o = sample_i.audio;
      POS_STAT:  byte_o = status;
      default:   byte_o = EOF;
    endcase
  end
endmodule

// File: rtl/sensor_frame_packer.sv
module sensor_frame_packer
  import sfp_pkg::*;
#(
  parameter logic [7:0] SOF0 = 8'h45,
  parameter logic [7:0] SOF1 = 8'h47,
  parameter logic [7:0] EOF  = 8'h59
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        send_i,
  input  logic [15:0] range_left_i,
  input  logic [15:0] range_right_i,
  input  logic [7:0]  audio_i,
  input  logic        pres_right_i,
  input  logic        pres_left_i,
  input  logic [5:0]  gp_i,
  input  logic        tx_ready_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o
);
  sample_t          live, held;
  logic             load;
  logic [IDX_W-1:0] idx;

  assign live = '{range_left: range_left_i, range_right: range_right_i,
                  audio: audio_i, pres_right: pres_right_i,
                  pres_left: pres_left_i, gp: gp_i};

  sfp_sequencer u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .send_i(send_i), .ready_i(tx_ready_i),
    .active_o(tx_valid_o), .load_o(load), .idx_o(idx)
  );

  sfp_snapshot u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .sample_i(live), .sample_o(held)
  );

  sfp_byte_mux #(.SOF0(SOF0), .SOF1(SOF1), .EOF(EOF)) u_mux (
    .idx_i(idx), .sample_i(held), .byte_o(tx_data_o)
  );

  assert_open_sof_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> tx_data_o == SOF0);

  assert_hold_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o && send_i |=> tx_valid_o);
endmodule

// File: tb/sensor_frame_packer_bench.sv
module sensor_frame_packer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        send_i = 1'b0;
  logic [15:0] range_left_i = '0, range_right_i = '0;
  logic [7:0]  audio_i = '0;
  logic        pres_right_i = 1'b0, pres_left_i = 1'b0;
  logic [5:0]  gp_i = '0;
  logic        tx_ready_i = 1'b0;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] got [9];
  int nrecv;

  always #2 clk_i = ~clk_i;

  sensor_frame_packer u_sensor_frame_packer (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_inputs(input logic [15:0] l, input logic [15:0] r, input logic [7:0] a,
                            input logic pr, input logic pl, input logic [5:0] g);
    range_left_i = l; range_right_i = r; audio_i = a;
    pres_right_i = pr; pres_left_i = pl; gp_i = g;
  endtask

  // Pulse send for one cycle; on return (negedge) valid should already be high.
  task automatic start_frame();
    @(negedge clk_i); send_i = 1'b1;
    @(negedge clk_i); send_i = 1'b0;
    chk("R2 valid after strobe", 32'(tx_valid_o), 32'd1);
  endtask

  // mode 0: ready always; mode 1: stalls. scramble: toggle inputs/send mid-frame.
  task automatic recv_frame(input int mode, input bit scramble);
    int cyc = 0;
    logic pv = 1'b0, pstall = 1'b0;
    logic [7:0] pd = '0;
    nrecv = 0;
    while (nrecv < 9 && cyc < 300) begin
      tx_ready_i = (mode == 0) ? 1'b1 : (cyc % 3 == 1);
      if (scramble) begin
        set_inputs(16'(cyc * 7919), 16'(cyc * 104729), 8'(cyc * 13), cyc[0], cyc[1], 6'(cyc));
        send_i = cyc[0];
      end
      if (pv && pstall) begin
        chk("R7 valid held in stall", 32'(tx_valid_o), 32'd1);
        chk("R7 data held in stall", 32'(tx_data_o), 32'(pd));
      end
      if (tx_valid_o && tx_ready_i) begin
        got[nrecv] = tx_data_o;
        nrecv++;
      end
      pv = tx_valid_o; pd = tx_data_o; pstall = !tx_ready_i;
      cyc++;
      @(negedge clk_i);
    end
    if (scramble) send_i = 1'b0;
    tx_ready_i = 1'b0;
    chk("R2 nine bytes", 32'(nrecv), 32'd9);
  endtask

  task automatic check_frame(input logic [15:0] l, input logic [15:0] r, input logic [7:0] a,
                             input logic pr, input logic pl, input logic [5:0] g);
    chk("R3 byte0", 32'(got[0]), 32'h45);
    chk("R3 byte1", 32'(got[1]), 32'h47);
    chk("R4 left hi", 32'(got[2]), 32'(l[15:8]));
    chk("R4 left lo", 32'(got[3]), 32'(l[7:0]));
    chk("R4 right hi", 32'(got[4]), 32'(r[15:8]));
    chk("R4 right lo", 32'(got[5]), 32'(r[7:0]));
    chk("R5 audio", 32'(got[6]), 32'(a));
    chk("R5 status", 32'(got[7]), 32'({pr, pl, g}));
    chk("R3 byte8", 32'(got[8]), 32'h59);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 valid low in reset", 32'(tx_valid_o), 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 valid low after reset", 32'(tx_valid_o), 32'd0);
  endtask

  task automatic t_basic();
    set_inputs(16'h1234, 16'hABCD, 8'h5E, 1'b1, 1'b0, 6'h2A);
    start_frame();
    recv_frame(0, 1'b0);
    check_frame(16'h1234, 16'hABCD, 8'h5E, 1'b1, 1'b0, 6'h2A);
    chk("R8 valid low after frame", 32'(tx_valid_o), 32'd0);
  endtask

  task automatic t_stall();
    set_inputs(16'hFFFF, 16'h0001, 8'h00, 1'b0, 1'b1, 6'h15);
    start_frame();
    recv_frame(1, 1'b0);
    check_frame(16'hFFFF, 16'h0001, 8'h00, 1'b0, 1'b1, 6'h15);
  endtask

  task automatic t_mid_change();
    set_inputs(16'h0F0F, 16'hF00F, 8'hC3, 1'b1, 1'b1, 6'h3F);
    start_frame();
    recv_frame(1, 1'b1);
    check_frame(16'h0F0F, 16'hF00F, 8'hC3, 1'b1, 1'b1, 6'h3F); // R6 snapshot kept
    chk("R8 idle right after frame", 32'(tx_valid_o), 32'd0);
    repeat (5) @(negedge clk_i);
    chk("R8 stays idle without strobe", 32'(tx_valid_o), 32'd0);
  endtask

  task automatic t_back_to_back();
    set_inputs(16'h8001, 16'h7FFE, 8'h99, 1'b0, 1'b0, 6'h01);
    @(negedge clk_i); send_i = 1'b1;
    @(negedge clk_i);
    set_inputs(16'h4242, 16'h2424, 8'h11, 1'b1, 1'b0, 6'h20);
    recv_frame(0, 1'b0);
    check_frame(16'h8001, 16'h7FFE, 8'h99, 1'b0, 1'b0, 6'h01);
    chk("R9 strobe at final handshake ignored", 32'(tx_valid_o), 32'd0);
    @(negedge clk_i);
    send_i = 1'b0;
    chk("R9 held strobe restarts", 32'(tx_valid_o), 32'd1);
    recv_frame(0, 1'b0);
    check_frame(16'h4242, 16'h2424, 8'h11, 1'b1, 1'b0, 6'h20);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_mid_change();
    t_back_to_back();
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule